// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral and Backoff Sequencer

This block decides, for one port of a two-port switch, when a frame may go onto the wire and when a jam must be sent instead. A frame source raises a transmit request and marks the end of the frame with a one-cycle done strobe. The block holds transmit-enable low until the line has been quiet for a full interframe gap. In half duplex, a collision during the frame turns the transmit into a jam. The jam is followed by a random wait, counted in slot times, after which a retry pulse tells the source to contend again. Once the per-frame attempt limit is used up, the block raises an abort pulse instead.

The same jam generator also provides flow control. When the buffer-usage alarm is high and a frame starts arriving on this port in half duplex, the block jams the line once. The resulting collision makes the remote sender back off. Two straps are sampled while reset is held. One shortens the backoff range and the other disables forced collisions. A speed input selects how many clock cycles make up one bit time. A free-running LFSR supplies the random slot counts. Moving data, generating CRC and storing frames are handled elsewhere.

Top module: `hdx_tx_defer`

## Requirements
- R1: In half duplex, `tx_en_o` rises only after `crs_i` has been low for IFG_BITS consecutive bit times while the block is not driving the line. A carrier during the count restarts it. With the request held, `tx_en_o` rises on the clock edge after the count completes.
- R2: In half duplex, `col_i` seen while a frame is being sent raises `jam_on_o` (with `tx_en_o` kept high) on the next clock edge. The jam lasts exactly JAM_BITS bit times.
- R3: After a non-final jam, the block waits s × SLOT_BITS bit times and then gives a one-cycle `retry_o` pulse, with `tx_en_o` low. Here s is the LFSR value masked to e bits, so 0 ≤ s ≤ 2^e − 1, and e = min(n, cap), where n is the number of collisions on the current frame.
- R4: The backoff exponent cap is STD_EXP_CAP (default 10) when `strap_bo4_i` was 0 during reset, and ALT_EXP_CAP (default 4) when it was 1. Changes to the strap after reset have no effect.
- R5: In full duplex (`full_dup_i` = 1), `col_i` never causes a jam and `crs_i` does not delay the start of transmission.
- R6: The RETRY_LIMIT-th collision (default 16) on a frame ends its jam with a one-cycle `abort_o` pulse instead of a backoff. The attempt count then restarts, so the next collision uses e = 1.
- R7: With forced collisions enabled, half duplex, `buf_alarm_i` high and `rx_crs_i` high while idle, the block jams for JAM_BITS bit times starting on the next edge. It jams only once per incoming carrier, and not at all while the alarm is low.
- R8: With `strap_bp_off_i` = 1 during reset, no jam ever starts unless a frame was being sent.
- R9: One bit time is FAST_DIV clock cycles when `speed_fast_i` = 1 and SLOW_DIV cycles when it is 0. The bit-time phase restarts on every state change, so a jam at slow speed lasts exactly JAM_BITS × SLOW_DIV cycles.
- R10: `frame_done_i` during a frame (with no collision in the same cycle) drops `tx_en_o` on the next edge. A completed frame, or a request withdrawn while idle, clears the attempt count.
- R11: While `rst_n_i` is low, and right after it rises, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous reset, active low; straps sampled while low |
| speed_fast_i | input | 1 | 1 selects the fast bit time, 0 the slow one |
| full_dup_i | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_req_i | input | 1 | Frame waiting to be sent |
| frame_done_i | input | 1 | One-cycle strobe marking the end of the frame |
| crs_i | input | 1 | Line carrier sense used for deferral |
| col_i | input | 1 | Collision detect |
| rx_crs_i | input | 1 | Incoming frame on this port |
| buf_alarm_i | input | 1 | Buffer usage above the flow-control threshold |
| strap_bo4_i | input | 1 | Reset strap: short backoff range |
| strap_bp_off_i | input | 1 | Reset strap: disable forced collisions |
| tx_en_o | output | 1 | Line driven (frame or jam) |
| jam_on_o | output | 1 | Jam pattern being sent |
| retry_o | output | 1 | One-cycle pulse: backoff complete, contend again |
| abort_o | output | 1 | One-cycle pulse: attempt limit reached, frame dropped |

## Verification
The bench drives inputs on the falling edge and reads outputs on the following falling edge, so every result is due a whole number of cycles after its stimulus. The last quiet-carrier sample completes the gap after IFG_BITS edges, and `tx_en_o` follows one edge later. `jam_on_o` follows one edge after a collision or a forced-jam condition and lasts JAM_BITS cycles at the fast speed (JAM_BITS × SLOW_DIV at slow speed). `abort_o` shows on the same cycle the jam ends. `retry_o` shows s × SLOT_BITS + 1 cycles after the jam ends, so the bench recovers s from the measured count and checks both its divisibility and its bound. Randomness is never predicted; only these bounds are checked.

// File: rtl/hdx_tx_pkg.sv
package hdx_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEND,
      ST_JAM,
      ST_WAIT,
      ST_FORCE,
      ST_HOLD
   } seq_state_e;

   // counter width able to hold values 0 .. n-1, never below one bit
   function automatic int unsigned cw(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/hdx_bit_clock.sv
module hdx_bit_clock #(
   parameter int unsigned FAST_DIV = 1,
   parameter int unsigned SLOW_DIV = 10
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic fast_i,
   input  logic clr_i,
   output logic tick_o
);
   import hdx_tx_pkg::*;

   localparam int unsigned MAXD = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
   localparam int unsigned CW   = cw(MAXD);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;

   assign lim    = fast_i ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
   assign tick_o = (cnt_q >= lim);

   always_ff @(posedge clk_i) begin
      if (!rst_n_i)              cnt_q <= '0;
      else if (clr_i || tick_o)  cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/hdx_rand_src.sv
module hdx_rand_src #(
   parameter int unsigned      W    = 10,
   parameter logic [W-1:0]     TAPS = 10'h080,
   parameter logic [W-1:0]     SEED = 10'h2A5
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q_q;
   logic [W-1:0] nxt;

   for (genvar g = 0; g < W; g++) begin : g_bit
      if (g == 0) begin : g_lsb
         assign nxt[g] = q_q[W-1];
      end else begin : g_mid
         assign nxt[g] = q_q[g-1] ^ (TAPS[g] & q_q[W-1]);
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) q_q <= SEED;
      else          q_q <= nxt;
   end

   assign q_o = q_q;

endmodule

// File: rtl/hdx_ifg_watch.sv
module hdx_ifg_watch #(
   parameter int unsigned IFG_BITS = 96
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic tick_i,
   input  logic busy_i,
   output logic gap_ok_o
);
   import hdx_tx_pkg::*;

   localparam int unsigned GW = cw(IFG_BITS + 1);

   logic [GW-1:0] gap_q;

   assign gap_ok_o = (gap_q == GW'(IFG_BITS));

   always_ff @(posedge clk_i) begin
      if (!rst_n_i)                 gap_q <= '0;
      else if (busy_i)              gap_q <= '0;
      else if (tick_i && !gap_ok_o) gap_q <= gap_q + 1'b1;
   end

endmodule

// File: rtl/hdx_backoff_timer.sv
module hdx_backoff_timer #(
   parameter int unsigned SLOT_BITS = 512,
   parameter int unsigned RW        = 10
) (
   input  logic          clk_i,
   input  logic          rst_n_i,
   input  logic          tick_i,
   input  logic          load_i,
   input  logic          run_i,
   input  logic [RW-1:0] slots_i,
   output logic          done_o
);
   import hdx_tx_pkg::*;

   localparam int unsigned SW = cw(SLOT_BITS);

   logic [RW-1:0] left_q;
   logic [SW-1:0] bit_q;

   assign done_o = run_i && (left_q == '0);

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         left_q <= '0;
         bit_q  <= '0;
      end else if (load_i) begin
         left_q <= slots_i;
         bit_q  <= '0;
      end else if (run_i && tick_i && (left_q != '0)) begin
         if (bit_q == SW'(SLOT_BITS - 1)) begin
            bit_q  <= '0;
            left_q <= left_q - 1'b1;
         end else begin
            bit_q  <= bit_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/hdx_tx_defer.sv
module hdx_tx_defer #(
   parameter int unsigned          FAST_DIV    = 1,
   parameter int unsigned          SLOW_DIV    = 10,
   parameter int unsigned          IFG_BITS    = 96,
   parameter int unsigned          SLOT_BITS   = 512,
   parameter int unsigned          JAM_BITS    = 32,
   parameter int unsigned          RETRY_LIMIT = 16,
   parameter int unsigned          STD_EXP_CAP = 10,
   parameter int unsigned          ALT_EXP_CAP = 4,
   parameter int unsigned          LFSR_W      = 10,
   parameter logic [LFSR_W-1:0]    LFSR_TAPS   = 10'h080,
   parameter logic [LFSR_W-1:0]    LFSR_SEED   = 10'h2A5
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic speed_fast_i,
   input  logic full_dup_i,
   input  logic tx_req_i,
   input  logic frame_done_i,
   input  logic crs_i,
   input  logic col_i,
   input  logic rx_crs_i,
   input  logic buf_alarm_i,
   input  logic strap_bo4_i,
   input  logic strap_bp_off_i,
   output logic tx_en_o,
   output logic jam_on_o,
   output logic retry_o,
   output logic abort_o
);
   import hdx_tx_pkg::*;

   localparam int unsigned AW = cw(RETRY_LIMIT + 1);
   localparam int unsigned JW = cw(JAM_BITS);
   localparam int unsigned EW = cw(LFSR_W + 1);
   localparam logic [EW-1:0] CAP_STD = EW'(STD_EXP_CAP);
   localparam logic [EW-1:0] CAP_ALT = EW'(ALT_EXP_CAP);

   // elaboration-time parameter checks
   if (FAST_DIV < 1 || SLOW_DIV < 1) begin : g_bad_div
      $error("bit-time dividers must be at least 1");
   end
   if (JAM_BITS < 1 || SLOT_BITS < 1 || IFG_BITS < 1) begin : g_bad_len
      $error("jam, slot and gap lengths must be at least 1");
   end
   if (STD_EXP_CAP > LFSR_W || ALT_EXP_CAP > STD_EXP_CAP) begin : g_bad_cap
      $error("exponent caps must satisfy ALT <= STD <= LFSR width");
   end
   if (RETRY_LIMIT < 1) begin : g_bad_limit
      $error("retry limit must be at least 1");
   end
   if (LFSR_SEED == '0) begin : g_bad_seed
      $error("random source seed must be nonzero");
   end

   seq_state_e st_q, st_d;

   logic              bo4_q, bp_en_q;
   logic [AW-1:0]     att_q;
   logic [JW-1:0]     jc_q;
   logic              retry_q, abort_q;
   logic              att_inc, att_clr, bo_load, retry_d, abort_d;
   logic              tick, phase_clr, gap_ok, bo_done, busy;
   logic              in_jam, jam_last, bp_go;
   logic [LFSR_W-1:0] rnd, mask, slots;
   logic [EW-1:0]     cap_now, exp_now;

   // straps are captured only while reset is held
   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         bo4_q   <= strap_bo4_i;
         bp_en_q <= !strap_bp_off_i;
      end
   end

   assign in_jam    = (st_q == ST_JAM) || (st_q == ST_FORCE);
   assign tx_en_o   = (st_q == ST_SEND) || in_jam;
   assign jam_on_o  = in_jam;
   assign retry_o   = retry_q;
   assign abort_o   = abort_q;
   assign phase_clr = (st_d != st_q);
   assign busy      = (!full_dup_i && crs_i) || tx_en_o;
   assign bp_go     = bp_en_q && !full_dup_i && buf_alarm_i && rx_crs_i;
   assign jam_last  = in_jam && tick && (jc_q == JW'(JAM_BITS - 1));

   hdx_bit_clock #(
      .FAST_DIV (FAST_DIV),
      .SLOW_DIV (SLOW_DIV)
   ) u_bitclk (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .fast_i  (speed_fast_i),
      .clr_i   (phase_clr),
      .tick_o  (tick)
   );

   hdx_ifg_watch #(
      .IFG_BITS (IFG_BITS)
   ) u_ifg (
      .clk_i    (clk_i),
      .rst_n_i  (rst_n_i),
      .tick_i   (tick),
      .busy_i   (busy),
      .gap_ok_o (gap_ok)
   );

   hdx_rand_src #(
      .W    (LFSR_W),
      .TAPS (LFSR_TAPS),
      .SEED (LFSR_SEED)
   ) u_rand (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .q_o     (rnd)
   );

   // slot count: random value masked to min(attempts, cap) bits
   assign cap_now = bo4_q ? CAP_ALT : CAP_STD;
   assign exp_now = (32'(att_q) > 32'(cap_now)) ? cap_now : EW'(att_q);
   assign mask    = (LFSR_W'(1) << exp_now) - LFSR_W'(1);
   assign slots   = rnd & mask;

   hdx_backoff_timer #(
      .SLOT_BITS (SLOT_BITS),
      .RW        (LFSR_W)
   ) u_backoff (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .tick_i  (tick),
      .load_i  (bo_load),
      .run_i   (st_q == ST_WAIT),
      .slots_i (slots),
      .done_o  (bo_done)
   );

   always_comb begin
      st_d    = st_q;
      att_inc = 1'b0;
      att_clr = 1'b0;
      bo_load = 1'b0;
      retry_d = 1'b0;
      abort_d = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (!tx_req_i) att_clr = 1'b1;
            if (bp_go)                      st_d = ST_FORCE;
            else if (tx_req_i && gap_ok)    st_d = ST_SEND;
         end
         ST_SEND: begin
            if (!full_dup_i && col_i) begin
               st_d    = ST_JAM;
               att_inc = 1'b1;
            end else if (frame_done_i) begin
               st_d    = ST_IDLE;
               att_clr = 1'b1;
            end
         end
         ST_JAM: begin
            if (jam_last) begin
               if (att_q == AW'(RETRY_LIMIT)) begin
                  st_d    = ST_IDLE;
                  abort_d = 1'b1;
                  att_clr = 1'b1;
               end else begin
                  st_d    = ST_WAIT;
                  bo_load = 1'b1;
               end
            end
         end
         ST_WAIT: begin
            if (bo_done) begin
               st_d    = ST_IDLE;
               retry_d = 1'b1;
            end
         end
         ST_FORCE: begin
            if (jam_last) st_d = ST_HOLD;
         end
         ST_HOLD: begin
            if (!rx_crs_i) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         st_q    <= ST_IDLE;
         att_q   <= '0;
         jc_q    <= '0;
         retry_q <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         retry_q <= retry_d;
         abort_q <= abort_d;
         if (att_clr)      att_q <= '0;
         else if (att_inc) att_q <= att_q + 1'b1;
         if (phase_clr)             jc_q <= '0;
         else if (in_jam && tick)   jc_q <= jc_q + 1'b1;
      end
   end

endmodule

// File: rtl/hdx_tx_defer_chk.sv
module hdx_tx_defer_chk (
   input logic clk,
   input logic rst_n,
   input logic full_dup,
   input logic rx_crs,
   input logic alarm,
   input logic tx_en,
   input logic jam_on,
   input logic retry,
   input logic abort_req,
   input logic gap_ok,
   input logic bp_en
);

   p_tx_after_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tx_en) && !jam_on) |-> $past(gap_ok));

   p_jam_on_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
      jam_on |-> tx_en);

   p_retry_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      retry |=> !retry);

   p_retry_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      retry |-> !tx_en);

   p_full_no_jam_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (full_dup && !jam_on) |=> !jam_on);

   p_abort_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |=> !abort_req);

   p_end_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({retry, abort_req}));

   p_forced_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(jam_on) && !$past(tx_en)) |-> $past(rx_crs && alarm && bp_en));

   p_no_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!bp_en && $rose(jam_on)) |-> $past(tx_en));

endmodule

bind hdx_tx_defer hdx_tx_defer_chk u_chk (
   .clk       (clk_i),
   .rst_n     (rst_n_i),
   .full_dup  (full_dup_i),
   .rx_crs    (rx_crs_i),
   .alarm     (buf_alarm_i),
   .tx_en     (tx_en_o),
   .jam_on    (jam_on_o),
   .retry     (retry_o),
   .abort_req (abort_o),
   .gap_ok    (gap_ok),
   .bp_en     (bp_en_q)
);

// File: tb/test_hdx_tx_defer.sv
module test_hdx_tx_defer;

   localparam int IFG   = 12;
   localparam int SLOT  = 4;
   localparam int JAM   = 4;
   localparam int SLOWD = 10;
   localparam int LIMIT = 16;

   logic clk = 1'b0;
   logic rst_n, speed_fast, full_dup, tx_req, frame_done, crs, col;
   logic rx_crs, buf_alarm, strap_bo4, strap_bp_off;
   logic tx_en, jam_on, retry, abort_p;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;

   always #4 clk = ~clk;

   hdx_tx_defer #(
      .FAST_DIV (1), .SLOW_DIV (SLOWD), .IFG_BITS (IFG),
      .SLOT_BITS (SLOT), .JAM_BITS (JAM), .RETRY_LIMIT (LIMIT)
   ) i_hdx_tx_defer (
      .clk_i (clk), .rst_n_i (rst_n), .speed_fast_i (speed_fast),
      .full_dup_i (full_dup), .tx_req_i (tx_req), .frame_done_i (frame_done),
      .crs_i (crs), .col_i (col), .rx_crs_i (rx_crs), .buf_alarm_i (buf_alarm),
      .strap_bo4_i (strap_bo4), .strap_bp_off_i (strap_bp_off),
      .tx_en_o (tx_en), .jam_on_o (jam_on), .retry_o (retry), .abort_o (abort_p)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic bo4, input logic bpoff);
      rst_n = 1'b0; strap_bo4 = bo4; strap_bp_off = bpoff;
      speed_fast = 1'b1; full_dup = 1'b0; tx_req = 1'b0; frame_done = 1'b0;
      crs = 1'b0; col = 1'b0; rx_crs = 1'b0; buf_alarm = 1'b0;
      step(3);
      chk({tx_en, jam_on, retry, abort_p} == 4'b0, "R11", "outputs in reset",
          {tx_en, jam_on, retry, abort_p}, 0);
      rst_n = 1'b1;
      step(1);
      chk({tx_en, jam_on, retry, abort_p} == 4'b0, "R11", "outputs after reset",
          {tx_en, jam_on, retry, abort_p}, 0);
   endtask

   task automatic wait_tx(input int lim, input string req);
      int n = 0;
      while (!tx_en && n < lim) begin step(1); n++; end
      chk(tx_en == 1'b1, req, "transmit start while waiting", tx_en, 1);
   endtask

   // one collision on the frame currently being sent; returns slot count or -1
   task automatic collide(input int k, input int cap, output int s);
      int jl, m, e;
      col = 1'b1;
      step(1);
      chk(jam_on && tx_en, "R2", "jam after collision", {jam_on, tx_en}, 3);
      col = 1'b0;
      jl = 1;
      for (int i = 0; i < 1000; i++) begin
         step(1);
         if (!jam_on) break;
         jl++;
      end
      chk(jl == JAM, "R2", "jam length in cycles", jl, JAM);
      s = -1;
      if (k == LIMIT) begin
         chk(abort_p == 1'b1, "R6", "abort at attempt limit", abort_p, 1);
         step(1);
         chk(!abort_p && !retry, "R6", "abort single pulse, no retry",
             {abort_p, retry}, 0);
      end else begin
         chk(abort_p == 1'b0, "R6", "no abort before limit", abort_p, 0);
         m = 0;
         for (int i = 0; i < 6000; i++) begin
            step(1);
            m++;
            if (retry) break;
         end
         chk(retry == 1'b1, "R3", "retry pulse after backoff", retry, 1);
         chk((m - 1) % SLOT == 0, "R3", "backoff whole slots (cycles-1)", m - 1, SLOT);
         s = (m - 1) / SLOT;
         e = (k < cap) ? k : cap;
         chk(s <= (1 << e) - 1, "R3", "slot count bound", s, (1 << e) - 1);
         chk(s <= (1 << cap) - 1, "R4", "slot count within cap", s, (1 << cap) - 1);
      end
   endtask

   task automatic run_to_abort(input int cap, output bit saw_big);
      int s;
      saw_big = 1'b0;
      tx_req = 1'b1;
      wait_tx(200, "R1");
      for (int k = 1; k <= LIMIT; k++) begin
         collide(k, cap, s);
         if (s > 15) saw_big = 1'b1;
         if (k < LIMIT) wait_tx(200, "R3");
      end
      // count restarted: next collision draws from one bit only
      wait_tx(200, "R6");
      collide(1, 1, s);
      chk(s >= 0 && s <= 1, "R6", "first draw after abort", s, 1);
      wait_tx(200, "R6");
      frame_done = 1'b1; tx_req = 1'b0;
      step(1);
      frame_done = 1'b0;
      chk(tx_en == 1'b0, "R10", "tx_en drops after frame_done", tx_en, 0);
   endtask

   task automatic test_gap();
      crs = 1'b1;
      step(3);
      tx_req = 1'b1;
      step(2);
      chk(tx_en == 1'b0, "R1", "deferred under carrier", tx_en, 0);
      crs = 1'b0;
      step(5);
      crs = 1'b1;
      step(1);
      chk(tx_en == 1'b0, "R1", "short gap not enough", tx_en, 0);
      crs = 1'b0;
      step(IFG);
      chk(tx_en == 1'b0, "R1", "no start before gap complete", tx_en, 0);
      step(1);
      chk(tx_en == 1'b1, "R1", "start one edge after gap", tx_en, 1);
      step(3);
      frame_done = 1'b1; tx_req = 1'b0;
      step(1);
      frame_done = 1'b0;
      chk(tx_en == 1'b0, "R10", "frame_done ends transmit", tx_en, 0);
   endtask

   task automatic test_std_backoff();
      bit big;
      run_to_abort(10, big);
      chk(big, "R4", "standard cap reaches above 15 slots", big, 1);
   endtask

   task automatic test_short_backoff();
      bit big;
      do_reset(1'b1, 1'b0);
      strap_bo4 = 1'b0;                // late change must be ignored
      step(IFG + 2);
      run_to_abort(4, big);
      chk(!big, "R4", "short cap stays within 15 slots", big, 0);
   endtask

   task automatic test_full_duplex();
      step(IFG + 4);
      full_dup = 1'b1; crs = 1'b1; tx_req = 1'b1;
      step(1);
      chk(tx_en == 1'b1, "R5", "carrier ignored in full duplex", tx_en, 1);
      col = 1'b1;
      for (int i = 0; i < 6; i++) begin
         step(1);
         chk(tx_en && !jam_on, "R5", "collision ignored in full duplex",
             {tx_en, jam_on}, 2);
      end
      col = 1'b0;
      frame_done = 1'b1; tx_req = 1'b0;
      step(1);
      frame_done = 1'b0; full_dup = 1'b0; crs = 1'b0;
      chk(tx_en == 1'b0, "R10", "full duplex frame end", tx_en, 0);
   endtask

   task automatic test_backpressure();
      int jl = 0;
      rx_crs = 1'b1;
      step(3);
      chk(jam_on == 1'b0, "R7", "no forced jam without alarm", jam_on, 0);
      rx_crs = 1'b0;
      step(2);
      buf_alarm = 1'b1; rx_crs = 1'b1;
      step(1);
      chk(jam_on == 1'b1, "R7", "forced jam next edge", jam_on, 1);
      for (int i = 0; i < 100; i++) begin
         if (!jam_on) break;
         jl++;
         step(1);
      end
      chk(jl == JAM, "R7", "forced jam length", jl, JAM);
      for (int i = 0; i < 5; i++) begin
         step(1);
         chk(jam_on == 1'b0, "R7", "single jam per carrier", jam_on, 0);
      end
      rx_crs = 1'b0;
      step(2);
      rx_crs = 1'b1;
      step(1);
      chk(jam_on == 1'b1, "R7", "jam again on new carrier", jam_on, 1);
      rx_crs = 1'b0; buf_alarm = 1'b0;
      step(JAM + 3);
   endtask

   task automatic test_bp_disabled();
      do_reset(1'b0, 1'b1);
      buf_alarm = 1'b1; rx_crs = 1'b1;
      for (int i = 0; i < 10; i++) begin
         step(1);
         chk(jam_on == 1'b0, "R8", "no forced jam when disabled", jam_on, 0);
      end
      buf_alarm = 1'b0; rx_crs = 1'b0;
   endtask

   task automatic test_slow_speed();
      int jl = 1;
      speed_fast = 1'b0;
      tx_req = 1'b1;
      wait_tx(IFG * SLOWD * 3, "R9");
      col = 1'b1;
      step(1);
      col = 1'b0;
      chk(jam_on == 1'b1, "R9", "jam at slow speed", jam_on, 1);
      for (int i = 0; i < 1000; i++) begin
         step(1);
         if (!jam_on) break;
         jl++;
      end
      chk(jl == JAM * SLOWD, "R9", "slow jam length in cycles", jl, JAM * SLOWD);
      tx_req = 1'b0;
      for (int i = 0; i < 1000; i++) begin
         if (retry) break;
         step(1);
      end
      chk(retry == 1'b1, "R9", "retry at slow speed", retry, 1);
      speed_fast = 1'b1;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
   endtask

   initial begin
      do_reset(1'b0, 1'b0);
      test_gap();
      test_std_backoff();
      test_full_duplex();
      test_backpressure();
      test_short_backoff();
      test_slow_speed();
      test_bp_disabled();
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end

endmodule